// File: doc/BRIEF.md
# Reloadable Up/Down Generate Timer

This block is a programmable counter that runs up or down once it is enabled. Its starting value comes from a load register. It signals a carry when it wraps past its terminal value. After a carry the counter does one of two things, chosen by a mode bit. It can reload the load value and keep running, which gives a periodic tick. It can also keep the wrapped value and switch itself off, which gives a one-shot.

Each carry can drive a one-cycle pulse on a dedicated output, and that pulse has its own enable. Each carry also sets a sticky interrupt status bit. Software clears that bit by writing a one to it, and the interrupt line is the status bit masked by a separate enable. Combining these settings gives repeated interrupts, single pulses and periodic waveforms.

Software reaches the block through a single-cycle write port and a combinational read port. There are three registers: control/status, load value, and the live count. The count is read-only.

Top module: `reload_gen_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped, and `gen_o` and `irq_o` are low.
- R2: When the run bit is 1, the count changes by one on every clock. When the run bit is 0 and no load is requested, the count holds.
- R3: When the direction bit is 1, the count decrements, and a carry occurs when a running count of zero steps on (it wraps to all-ones). When the direction bit is 0, the count increments, and a carry occurs when a running all-ones count steps on (it wraps to zero).
- R4: On a carry with the reload bit at 1, the next count is the load value and counting continues. Counting up from load value L, carries therefore repeat every 2^CNT_W - L clocks.
- R5: On a carry with the reload bit at 0, the count keeps the wrapped value and the run bit clears itself. The count then holds.
- R6: When the pulse enable is 1, `gen_o` is high for exactly the one cycle after each carry edge. When the pulse enable is 0, `gen_o` stays low.
- R7: The status bit (control bit 8) is set on every carry, whatever the interrupt enable is. It stays set until a control write has bit 8 at 1. If a carry and such a clear fall in the same cycle, the carry wins.
- R8: `irq_o` is high exactly when the status bit and the interrupt enable are both 1.
- R9: A control write with bit 5 at 1 copies the load register into the count on that clock, instead of counting. Bit 5 always reads back as 0.
- R10: The register map is as follows. Address 0 is control: bit 0 run, bit 1 down, bit 2 reload, bit 3 pulse enable, bit 4 interrupt enable, bit 5 load strobe, bit 8 status. Address 1 is the load value; it is CNT_W bits wide and reads back zero-extended. Address 2 is the count; it is read-only and writes to it are ignored. Address 3 reads zero. The read data follows `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one register per clock |
| wr_addr | input | 2 | Write register select |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | DATA_W | Read data for `rd_addr` |
| gen_o | output | 1 | One-cycle pulse after each carry when enabled |
| irq_o | output | 1 | Interrupt: status AND interrupt enable |

## Verification
The main function is exercised with four stimulus patterns:
- An up-count with reload from just below all-ones separates a correct period of 2^CNT_W - L from off-by-one wrap or reload errors.
- A down-count from a small value in stop mode shows whether the timer halts on the wrapped value and drops its run bit.
- A load value of all-ones with reload produces a carry on every clock. This tells a true one-cycle pulse per carry apart from a pulse that merges or gets skipped.
- A run with the pulse disabled shows that the status bit still records carries while `gen_o` and `irq_o` stay quiet.

A load strobe issued in the middle of a run shows that loading takes priority over the increment.

// File: rtl/rgt_pkg.sv
`timescale 1ns/1ps
package rgt_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_LOAD  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    localparam int unsigned BIT_RUN    = 0;
    localparam int unsigned BIT_DOWN   = 1;
    localparam int unsigned BIT_RELOAD = 2;
    localparam int unsigned BIT_GEN    = 3;
    localparam int unsigned BIT_IRQ    = 4;
    localparam int unsigned BIT_LOAD   = 5;
    localparam int unsigned BIT_STAT   = 8;
endpackage

// File: rtl/rgt_regs.sv
`timescale 1ns/1ps
module rgt_regs #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              carry_i,
    output logic              run_o,
    output logic              down_o,
    output logic              reload_o,
    output logic              gen_en_o,
    output logic              irq_en_o,
    output logic              status_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic              load_stb_o
);
    import rgt_pkg::*;

    typedef struct packed {
        logic             run;
        logic             down;
        logic             reload;
        logic             gen_en;
        logic             irq_en;
        logic             status;
        logic [CNT_W-1:0] load_val;
    } regs_t;

    regs_t q, d;
    logic  wr_ctrl;
    logic  wr_load;

    assign wr_ctrl = wr_en && (wr_addr == SEL_CTRL);
    assign wr_load = wr_en && (wr_addr == SEL_LOAD);

    always_comb begin
        d = q;
        if (wr_ctrl) begin
            d.run    = wr_data[BIT_RUN];
            d.down   = wr_data[BIT_DOWN];
            d.reload = wr_data[BIT_RELOAD];
            d.gen_en = wr_data[BIT_GEN];
            d.irq_en = wr_data[BIT_IRQ];
            if (wr_data[BIT_STAT]) begin
                d.status = 1'b0;
            end
        end
        if (wr_load) begin
            d.load_val = wr_data[CNT_W-1:0];
        end
        if (carry_i) begin
            d.status = 1'b1;
            if (!q.reload) begin
                d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign run_o      = q.run;
    assign down_o     = q.down;
    assign reload_o   = q.reload;
    assign gen_en_o   = q.gen_en;
    assign irq_en_o   = q.irq_en;
    assign status_o   = q.status;
    assign load_val_o = q.load_val;
    assign load_stb_o = wr_ctrl && wr_data[BIT_LOAD];

    // R5: a one-shot carry switches the timer off
    a_r5_stop_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_i && !q.reload && !wr_ctrl) |=> !q.run);

    // R7: every carry leaves the status bit set
    a_r7_carry_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        carry_i |=> q.status);

    // R7: status only drops through a clearing write
    a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q.status && !(wr_ctrl && wr_data[BIT_STAT])) |=> q.status);
endmodule

// File: rtl/rgt_count.sv
`timescale 1ns/1ps
module rgt_count #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             down_i,
    input  logic             reload_i,
    input  logic             gen_en_i,
    input  logic             load_stb_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             carry_o,
    output logic             gen_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             gen;
    } cnt_state_t;

    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_state_t q, d;
    logic       at_end;
    logic       carry;

    assign at_end = down_i ? (q.cnt == '0) : (q.cnt == ALL_ONES);
    assign carry  = run_i && !load_stb_i && at_end;

    always_comb begin
        d     = q;
        d.gen = carry && gen_en_i;
        if (load_stb_i) begin
            d.cnt = load_val_i;
        end else if (run_i) begin
            if (at_end && reload_i) begin
                d.cnt = load_val_i;
            end else if (down_i) begin
                d.cnt = q.cnt - ONE;
            end else begin
                d.cnt = q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cnt_o   = q.cnt;
    assign carry_o = carry;
    assign gen_o   = q.gen;

    // R2: idle counter holds its value
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_stb_i) |=> $stable(q.cnt));

    // R4: reload mode restarts from the load value after a terminal step
    a_r4_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_stb_i && reload_i && at_end) |=> (q.cnt == $past(load_val_i)));

    // R9: a load strobe overrides counting
    a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb_i |=> (q.cnt == $past(load_val_i)));

    // R6: the pulse only follows a running terminal count
    a_r6_pulse_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        q.gen |-> $past(run_i && at_end && gen_en_i));
endmodule

// File: rtl/rgt_readback.sv
`timescale 1ns/1ps
module rgt_readback #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic [1:0]        rd_addr,
    input  logic              run_i,
    input  logic              down_i,
    input  logic              reload_i,
    input  logic              gen_en_i,
    input  logic              irq_en_i,
    input  logic              status_i,
    input  logic [CNT_W-1:0]  load_val_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [DATA_W-1:0] rd_data
);
    import rgt_pkg::*;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            SEL_CTRL: begin
                rd_data[BIT_RUN]    = run_i;
                rd_data[BIT_DOWN]   = down_i;
                rd_data[BIT_RELOAD] = reload_i;
                rd_data[BIT_GEN]    = gen_en_i;
                rd_data[BIT_IRQ]    = irq_en_i;
                rd_data[BIT_STAT]   = status_i;
            end
            SEL_LOAD:  rd_data[CNT_W-1:0] = load_val_i;
            SEL_COUNT: rd_data[CNT_W-1:0] = cnt_i;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/reload_gen_timer.sv
`timescale 1ns/1ps
module reload_gen_timer #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              gen_o,
    output logic              irq_o
);
    logic             run, down, reload, gen_en, irq_en, status;
    logic             load_stb, carry;
    logic [CNT_W-1:0] load_val, cnt;

    rgt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .carry_i    (carry),
        .run_o      (run),
        .down_o     (down),
        .reload_o   (reload),
        .gen_en_o   (gen_en),
        .irq_en_o   (irq_en),
        .status_o   (status),
        .load_val_o (load_val),
        .load_stb_o (load_stb)
    );

    rgt_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .down_i     (down),
        .reload_i   (reload),
        .gen_en_i   (gen_en),
        .load_stb_i (load_stb),
        .load_val_i (load_val),
        .cnt_o      (cnt),
        .carry_o    (carry),
        .gen_o      (gen_o)
    );

    rgt_readback #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rb (
        .rd_addr    (rd_addr),
        .run_i      (run),
        .down_i     (down),
        .reload_i   (reload),
        .gen_en_i   (gen_en),
        .irq_en_i   (irq_en),
        .status_i   (status),
        .load_val_i (load_val),
        .cnt_i      (cnt),
        .rd_data    (rd_data)
    );

    assign irq_o = status && irq_en;

    // R8: the line never rises without an enabled, pending status
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (u_regs.status_o && u_regs.irq_en_o));
endmodule

// File: tb/reload_gen_timer_tb.sv
`timescale 1ns/1ps
module reload_gen_timer_tb;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 8;
    localparam logic [31:0] C_RUN = 32'h1, C_DOWN = 32'h2, C_REL = 32'h4,
                            C_GEN = 32'h8, C_IRQ = 32'h10, C_LD = 32'h20, C_STAT = 32'h100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [1:0]        rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              gen_o, irq_o;

    int checks = 0;
    int errors = 0;
    int ncyc = 0;
    int k;
    int exp_q[$];

    reload_gen_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .gen_o(gen_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    // Monitor: every pulse must match the next expected cycle in the queue
    always @(negedge clk) begin
        ncyc++;
        if (rst_n && gen_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R6 pulse at cycle %0d expected none", ncyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != ncyc) begin
                    errors++;
                    $display("FAIL R6 pulse at cycle %0d expected %0d", ncyc, e);
                end
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic chk_reg(string req, logic [1:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // Drive from just after a falling edge; returns just after the next falling edge
    task automatic wr(logic [1:0] a, logic [31:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(posedge clk);
        @(negedge clk);
        #1;
        wr_en = 1'b0;
        k = ncyc;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk_reg("R1 ctrl", 2'd0, 32'h0);
        chk_reg("R1 load", 2'd1, 32'h0);
        chk_reg("R1 count", 2'd2, 32'h0);
        chk("R1 gen_o", {31'b0, gen_o}, 32'h0);
        chk("R1 irq_o", {31'b0, irq_o}, 32'h0);

        // R10 map: count is read-only, load truncated, addr 3 is zero
        wr(2'd2, 32'h55);
        chk_reg("R10 count write ignored", 2'd2, 32'h0);
        wr(2'd1, 32'h1234_56FC);
        chk_reg("R10 load width", 2'd1, 32'hFC);
        chk_reg("R10 unused address", 2'd3, 32'h0);
        idle(3);
        chk_reg("R2 hold while stopped", 2'd2, 32'h0);

        // R9 load strobe, not retained
        wr(2'd0, C_LD);
        chk_reg("R9 load copied", 2'd2, 32'hFC);
        chk_reg("R9 strobe reads zero", 2'd0, 32'h0);

        // R4 up with reload from FC: period 4
        wr(2'd0, C_RUN | C_REL | C_GEN | C_IRQ);
        exp_q.push_back(k + 4); exp_q.push_back(k + 8); exp_q.push_back(k + 12);
        chk_reg("R4 start value", 2'd2, 32'hFC);
        idle(1);
        chk_reg("R2 increments", 2'd2, 32'hFD);
        idle(12);
        chk("R8 irq with enable", {31'b0, irq_o}, 32'h1);
        wr(2'd0, 32'h0);
        idle(2);
        chk_reg("R2 stopped holds", 2'd2, 32'hFE);
        chk_reg("R7 status sticky", 2'd0, C_STAT);
        chk("R8 irq masked", {31'b0, irq_o}, 32'h0);
        wr(2'd0, C_STAT);
        chk_reg("R7 status cleared", 2'd0, 32'h0);

        // R6 pulse disabled: no pulses, status still set
        wr(2'd1, 32'hFE);
        wr(2'd0, C_LD);
        wr(2'd0, C_RUN | C_REL);
        idle(6);
        chk("R8 irq disabled", {31'b0, irq_o}, 32'h0);
        wr(2'd0, 32'h0);
        chk_reg("R7 status set without enable", 2'd0, C_STAT);
        wr(2'd0, C_IRQ);
        chk("R8 irq follows enable", {31'b0, irq_o}, 32'h1);
        wr(2'd0, C_STAT);
        chk_reg("R7 clear", 2'd0, 32'h0);

        // R3/R5 down one-shot from 3
        wr(2'd1, 32'h03);
        wr(2'd0, C_LD);
        wr(2'd0, C_RUN | C_DOWN | C_GEN);
        exp_q.push_back(k + 4);
        idle(1);
        chk_reg("R3 decrements", 2'd2, 32'h02);
        idle(7);
        chk_reg("R5 wrapped value held", 2'd2, 32'hFF);
        chk_reg("R5 run cleared", 2'd0, C_STAT | C_DOWN | C_GEN);
        wr(2'd0, C_STAT);

        // R9 load beats counting mid-run
        wr(2'd1, 32'h10);
        wr(2'd0, C_LD);
        wr(2'd0, C_RUN | C_REL);
        idle(3);
        chk_reg("R2 running count", 2'd2, 32'h13);
        wr(2'd0, C_RUN | C_REL | C_LD);
        chk_reg("R9 load priority", 2'd2, 32'h10);
        idle(1);
        chk_reg("R9 counting resumes", 2'd2, 32'h11);
        wr(2'd0, 32'h0);

        // R6 carry every cycle from all-ones
        wr(2'd1, 32'hFF);
        wr(2'd0, C_LD);
        wr(2'd0, C_RUN | C_REL | C_GEN);
        for (int i = 1; i <= 5; i++) exp_q.push_back(k + i);
        idle(4);
        wr(2'd0, 32'h0);
        idle(4);
        chk("R6 all pulses seen", exp_q.size(), 32'h0);
        chk_reg("R4 all-ones reload", 2'd2, 32'hFF);
        finish_run();
    end
endmodule